// File: doc/BRIEF.md
# Conveyor Box Tally with Belt Stop

This block keeps a running decimal count of boxes passing a sensor on a conveyor and shows it on seven-segment displays, one display per decimal digit. The count is held as a chain of cascaded BCD digits. The least significant digit advances once for each box. Each digit carries into the next one when it rolls over from 9 to 0.

When the count reaches a programmed terminal value (23 by default), a stop flag is set on the falling clock edge and the belt-run output drops. While the flag is set, further sensor activity is ignored.

A single active-low push button serves as both the clear and the restart control. It is synchronized, and then acts as the synchronous reset of the whole block. Pressing it returns the count to 00 and raises belt-run again. The box sensor is synchronized too, and is then edge-detected, so a long pulse is counted only once.

Top module: `box_tally_top`

## Requirements
- R1: After the clear button (active-low) has been held and released, the count reads 00 on both BCD digits and belt_run is 1.
- R2: Each rising edge of box_sense increments the count by exactly one, whatever the length of the high pulse.
- R3: The units digit (tally_bcd[3:0]) counts 0 to 9. On the increment after 9 it returns to 0, and the tens digit (tally_bcd[7:4]) advances by one.
- R4: seg_n carries 7 bits per digit, with the units digit in bits [6:0] and the tens digit in bits [13:7]. Within each group, bit 0 is segment a and bit 6 is segment g. A 0 lights a segment. The lit segments for each digit value are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all, 9 abcdfg.
- R5: When the count equals the terminal value (tens 2, units 3), a stop flag is set on the next falling clock edge and belt_run goes to 0.
- R6: While stopped, sensor edges are ignored and the count stays at the terminal value.
- R7: Pressing the clear button while stopped returns the count to 00 and sets belt_run to 1, and counting resumes from there.
- R8: A clear that is active during the same cycles as a sensor edge wins, and the count is 00 after release.
- R9: No BCD digit ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| clear_btn_n | input | 1 | Push button, active-low, asynchronous; clears the count and restarts the belt |
| box_sense | input | 1 | Box sensor level, asynchronous; one rising edge per box |
| tally_bcd | output | NUM_DIGITS*4 | Count as BCD, units in the low nibble |
| seg_n | output | NUM_DIGITS*7 | Active-low segment patterns, 7 bits per digit |
| belt_run | output | 1 | High while the belt may run; low once the terminal count is reached |

## Verification
The bench builds the block with its default parameters: two digits, a terminal value of 23 and two-stage synchronizers. With these values the count can be stepped through every value from 00 to the stop point. Every step therefore compares both digits, both segment patterns and belt_run against values derived arithmetically from the running count. That sweep shows all ten units patterns and the units-to-tens carry twice. The remaining sequences cover pulses of different lengths, edges arriving while stopped, a clear given during a stop, and a clear that overlaps a sensor pulse.

// File: rtl/box_tally_pkg.sv
// Package: shared widths and helpers for the box tally block.
// Assumes: decimal digits coded as 4-bit BCD, seven segments per display.
package box_tally_pkg;
    localparam int BCD_W = 4;
    localparam int SEG_W = 7;
    localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;
    localparam logic [SEG_W-1:0] SEG_BLANK_N = 7'h7F;

    // Decimal digit number idx of a non-negative value.
    function automatic logic [BCD_W-1:0] dec_digit(input int value, input int idx);
        int v;
        v = value;
        for (int k = 0; k < idx; k++) v = v / 10;
        return BCD_W'(v % 10);
    endfunction
endpackage

// File: rtl/sync_chain.sv
// Module: sync_chain
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: STAGES >= 2; rst_n is synchronous active-low (tie high if none).
module sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the input level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bcd_digit.sv
// Module: bcd_digit
// One decimal counter digit: advances on inc, wraps 9 -> 0.
// Assumes: the carry to the next digit is formed outside from q and inc.
module bcd_digit
    import box_tally_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [BCD_W-1:0] q
);
    // Step the digit, wrapping after nine.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= '0;
        else if (inc) begin
            if (q == BCD_MAX) q <= '0;
            else              q <= q + 1'b1;
        end
    end

    a_r9_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        q <= BCD_MAX);
    a_r3_wrap_on_nine: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && q == BCD_MAX) |=> (q == '0));
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && q != BCD_MAX) |=> (q == $past(q) + 1'b1));
    a_r6_hold_without_inc: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(q));
endmodule

// File: rtl/seg7_decode.sv
// Module: seg7_decode
// Converts one BCD digit to an active-low segment pattern, bit0 = a .. bit6 = g.
// Assumes: codes 10..15 never reach it; if they do, the display goes blank.
module seg7_decode
    import box_tally_pkg::*;
(
    input  logic [BCD_W-1:0] bcd,
    output logic [SEG_W-1:0] seg_n
);
    // Look up the lit segments (active-high gfedcba), then invert.
    always_comb begin
        unique case (bcd)
            4'd0:    seg_n = ~7'h3F;
            4'd1:    seg_n = ~7'h06;
            4'd2:    seg_n = ~7'h5B;
            4'd3:    seg_n = ~7'h4F;
            4'd4:    seg_n = ~7'h66;
            4'd5:    seg_n = ~7'h6D;
            4'd6:    seg_n = ~7'h7D;
            4'd7:    seg_n = ~7'h07;
            4'd8:    seg_n = ~7'h7F;
            4'd9:    seg_n = ~7'h6F;
            default: seg_n = SEG_BLANK_N;
        endcase
    end
endmodule

// File: rtl/stop_latch.sv
// Module: stop_latch
// Single flop, updated on the falling clock edge, that remembers the terminal
// count was reached; only a synchronous clear releases it.
// Assumes: set and rst_n come from posedge logic and are settled by the falling edge.
module stop_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic stop_q
);
    // Capture the stop request on the falling edge; clear has priority.
    always_ff @(negedge clk) begin
        if (!rst_n)   stop_q <= 1'b0;
        else if (set) stop_q <= 1'b1;
    end

    a_r5_sets_after_term: assert property (@(negedge clk) disable iff (!rst_n)
        set |=> stop_q);
    a_r6_stays_stopped: assert property (@(negedge clk) disable iff (!rst_n)
        stop_q |=> stop_q);
endmodule

// File: rtl/box_tally_top.sv
// Module: box_tally_top
// Counts boxes as cascaded BCD digits, decodes each digit to seven segments and
// drops belt_run once the count reaches TERM_VALUE. The active-low clear button,
// after synchronizing, is the synchronous reset of the whole block.
// Assumes: TERM_VALUE fits in NUM_DIGITS decimal digits; box pulses are slow
// compared with clk.
module box_tally_top
    import box_tally_pkg::*;
#(
    parameter int NUM_DIGITS  = 2,
    parameter int TERM_VALUE  = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        clear_btn_n,
    input  logic                        box_sense,
    output logic [NUM_DIGITS*BCD_W-1:0] tally_bcd,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_n,
    output logic                        belt_run
);
    localparam int TALLY_W = NUM_DIGITS * BCD_W;

    logic               clr_n;
    logic               sense_sync;
    logic               sense_prev;
    logic               box_evt;
    logic               at_term;
    logic               count_en;
    logic               stop_q;
    logic [TALLY_W-1:0] term_bcd;
    logic [NUM_DIGITS-1:0] digit_inc;

    // Button synchronizer: it has no reset of its own, since it is the reset.
    sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_btn_sync (
        .clk     (clk),
        .rst_n   (1'b1),
        .d_async (clear_btn_n),
        .q_sync  (clr_n)
    );

    sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sense_sync (
        .clk     (clk),
        .rst_n   (clr_n),
        .d_async (box_sense),
        .q_sync  (sense_sync)
    );

    // Remember the previous synchronized level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!clr_n) sense_prev <= 1'b0;
        else        sense_prev <= sense_sync;
    end

    assign box_evt  = sense_sync & ~sense_prev;
    assign at_term  = (tally_bcd == term_bcd);
    assign count_en = box_evt & ~stop_q & ~at_term;

    generate
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
            assign term_bcd[i*BCD_W +: BCD_W] = dec_digit(TERM_VALUE, i);

            if (i == 0) begin : g_lsd
                assign digit_inc[0] = count_en;
            end else begin : g_upper
                assign digit_inc[i] = digit_inc[i-1] &
                                      (tally_bcd[(i-1)*BCD_W +: BCD_W] == BCD_MAX);
            end

            bcd_digit u_digit (
                .clk   (clk),
                .rst_n (clr_n),
                .inc   (digit_inc[i]),
                .q     (tally_bcd[i*BCD_W +: BCD_W])
            );

            seg7_decode u_seg (
                .bcd   (tally_bcd[i*BCD_W +: BCD_W]),
                .seg_n (seg_n[i*SEG_W +: SEG_W])
            );
        end
    endgenerate

    stop_latch u_stop (
        .clk    (clk),
        .rst_n  (clr_n),
        .set    (at_term),
        .stop_q (stop_q)
    );

    assign belt_run = ~stop_q;

    a_r5_stop_only_at_term: assert property (@(posedge clk) disable iff (!clr_n)
        stop_q |-> at_term);
    a_r6_frozen_when_stopped: assert property (@(posedge clk) disable iff (!clr_n)
        stop_q |=> $stable(tally_bcd));
    a_r2_one_per_edge: assert property (@(posedge clk) disable iff (!clr_n)
        $past(box_evt) |-> !box_evt);
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (tally_bcd == '0));
endmodule

// File: tb/tb_box_tally_top.sv
`timescale 1ns/1ps
module tb_box_tally_top;
    localparam int ND = 2;
    localparam int TERM = 23;

    logic            clk = 1'b0;
    logic            clear_btn_n;
    logic            box_sense;
    logic [ND*4-1:0] tally_bcd;
    logic [ND*7-1:0] seg_n;
    logic            belt_run;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_count = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    box_tally_top #(.NUM_DIGITS(ND), .TERM_VALUE(TERM), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .clear_btn_n (clear_btn_n),
        .box_sense   (box_sense),
        .tally_bcd   (tally_bcd),
        .seg_n       (seg_n),
        .belt_run    (belt_run)
    );

    // Active-low gfedcba pattern, built segment by segment from the digit value.
    function automatic logic [6:0] exp_seg(input int d);
        logic a, b, c, dd, e, f, g;
        a  = !(d == 1 || d == 4);
        b  = !(d == 5 || d == 6);
        c  = (d != 2);
        dd = !(d == 1 || d == 4 || d == 7);
        e  = (d == 0 || d == 2 || d == 6 || d == 8);
        f  = !(d == 1 || d == 2 || d == 3 || d == 7);
        g  = !(d == 0 || d == 1 || d == 7);
        return ~{g, f, e, dd, c, b, a};
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        int u, t;
        u = exp_count % 10;
        t = exp_count / 10;
        cmp(req, "units", int'(tally_bcd[3:0]), u);
        cmp(req, "tens", int'(tally_bcd[7:4]), t);
        cmp(req, "seg units", int'(seg_n[6:0]), int'(exp_seg(u)));
        cmp(req, "seg tens", int'(seg_n[13:7]), int'(exp_seg(t)));
        cmp(req, "belt_run", int'(belt_run), (exp_count == TERM) ? 0 : 1);
    endtask

    task automatic box(input int hold);
        @(negedge clk) box_sense = 1'b1;
        repeat (hold) @(negedge clk);
        box_sense = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic press(input int hold);
        @(negedge clk) clear_btn_n = 1'b0;
        repeat (hold) @(negedge clk);
        clear_btn_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        clear_btn_n = 1'b0;
        box_sense   = 1'b0;
        repeat (6) @(negedge clk);
        clear_btn_n = 1'b1;
        repeat (5) @(negedge clk);
        exp_count = 0;
        check_all("R1");

        // Sweep through every count up to the stop value (R2, R3, R4, R5).
        for (int i = 1; i <= TERM; i++) begin
            box(1 + (i % 3));
            exp_count = i;
            if (i % 10 == 0)   check_all("R3");
            else if (i == TERM) check_all("R5");
            else               check_all("R2_R4");
        end

        // Edges after the stop are ignored (R6).
        for (int k = 0; k < 4; k++) begin
            box(2 + k);
            check_all("R6");
        end

        // Clear while stopped restarts the belt (R7).
        press(4);
        exp_count = 0;
        check_all("R7");
        box(1);
        exp_count = 1;
        check_all("R7");

        // A very long pulse still counts once (R2).
        box(40);
        exp_count = 2;
        check_all("R2");

        // Clear overlapping a sensor pulse wins (R8).
        for (int k = 0; k < 3; k++) box(1);
        exp_count = 5;
        check_all("R2");
        @(negedge clk);
        clear_btn_n = 1'b0;
        box_sense   = 1'b1;
        repeat (8) @(negedge clk);
        box_sense = 1'b0;
        repeat (3) @(negedge clk);
        clear_btn_n = 1'b1;
        repeat (5) @(negedge clk);
        exp_count = 0;
        check_all("R8");

        // Second pass reaches the stop again after the restart.
        for (int i = 1; i <= TERM; i++) begin
            box(1);
            exp_count = i;
        end
        check_all("R5");
        box(3);
        check_all("R6");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule